// File: doc/BRIEF.md
# Memory Window Address Translator

This block sits between a 32-bit system bus and a PCI master. For every command it decides whether the system address falls into one of three fixed memory windows. The windows are 16 MB at `FD00_0000`, 64 MB at `1000_0000`, and 512 MB at `C000_0000`. The 512 MB window answers only while extended-address mode is on. For a hit, the block builds the PCI memory address. Two software-written registers supply the upper address bits: a bank value and a mask. The low bits of the system address are carried across unchanged.

The block also watches 32-byte line commands, both loads and stores. A run of line commands of the same direction, each exactly 32 bytes above the one before, is reported as a single PCI burst. The burst covers 32 bytes times the number of lines. The block marks where each burst starts, continues and ends. It generates no PCI bus cycles itself.

All outputs are combinational from the command presented in the current cycle. The bank and mask registers and the open-burst record are clocked. A synchronous reset clears them.

Top module: `memWinXlate`

## Requirements
- R1: An address with bits [31:24] equal to `FD` raises `hitWin[0]` only.
- R2: An address with bits [31:26] equal to `000100` raises `hitWin[1]` only.
- R3: An address with bits [31:29] equal to `110` raises `hitWin[2]` only while `extMode` is 1. With `extMode` at 0 that address is a miss.
- R4: A valid command that hits no window, including the register region at `FE00_0000` and the I/O region at `FE20_0000`, raises `miss`. It drives `pciAddr` to zero, raises no burst strobe, and leaves the open-burst record untouched.
- R5: Each bit of `pciAddr[31:18]` takes the bank bit where the mask bit is 1 and the address bit where it is 0. A write with `regSel`=0 loads the bank and a write with `regSel`=1 loads the mask. Only data bits [31:18] are kept. A write becomes visible from the next clock edge on, and a command in the same cycle still sees the old value.
- R6: `pciAddr[17:3]` always equals `cmdAddr[17:3]` on a hit. Bits [2:0] are copied for a single command and forced to zero for a line command.
- R7: `cmdKind` codes are 0 single, 1 line load, 2 line store and 3 treated as single. A hitting line command that does not continue the open burst raises `burstStart`.
- R8: A hitting line command raises `burstCont` instead of `burstStart` when three conditions hold. A burst must be open. The command must have the same direction and the same window as the previous line command. Its address must equal that command's address plus 32.
- R9: A hitting command that does not continue an open burst raises `burstEnd` in its own cycle, together with `burstStart` when it is a line command. A hitting single command closes the burst.
- R10: Cycles with `cmdValid` low leave an open burst open.
- R11: A synchronous reset clears bank, mask and the open burst, so the next hit translates to the unchanged address and cannot continue a burst.
- R12: With `cmdValid` low, all hit flags, `miss`, `pciAddr` and burst strobes are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command present this cycle |
| cmdKind | input | 2 | 0 single, 1 line load, 2 line store, 3 single |
| cmdAddr | input | 32 | System byte address |
| extMode | input | 1 | Enables the 512 MB window |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 bank register, 1 mask register |
| regWrData | input | 32 | Write data, bits [31:18] used |
| hitWin | output | 3 | One-hot window hit |
| miss | output | 1 | Valid command matched no window |
| pciAddr | output | 32 | Translated PCI memory address |
| burstStart | output | 1 | First line of a new burst |
| burstCont | output | 1 | Line extends the open burst |
| burstEnd | output | 1 | Open burst closed by this command |

## Verification
The hardest case to reach is a burst that survives gaps: idle cycles and missing commands fall between two adjacent lines, and the burst must still continue rather than restart. The stimulus table sets this up in two places. An idle vector sits in the middle of a run of loads. Later, a miss to the register region falls between two stores, and the second store is offset so that it continues only if the missing command left the recorded address alone. Directed tests then cover the same-cycle register write and a reset issued while a burst is open.

// File: rtl/memwin_pkg.sv
`timescale 1ns/1ps
package memwin_pkg;
  localparam int ADDR_W     = 32;
  localparam int NUM_WIN    = 3;
  localparam int KEEP_LSB   = 18;  // bits below this never translated
  localparam int BEAT_BITS  = 3;   // cleared for line commands
  localparam int LINE_BYTES = 32;

  localparam logic [ADDR_W-1:0] WIN_BASE [NUM_WIN] =
    '{32'hFD00_0000, 32'h1000_0000, 32'hC000_0000};
  localparam int WIN_LOG2 [NUM_WIN] = '{24, 26, 29};
  localparam logic [NUM_WIN-1:0] WIN_EXT_ONLY = 3'b100;

  typedef enum logic [1:0] {
    CMD_SINGLE  = 2'd0,
    CMD_LOAD32  = 2'd1,
    CMD_STORE32 = 2'd2,
    CMD_RSVD    = 2'd3
  } cmdKind_e;

  typedef struct packed {
    logic lineXfer;
    logic bStart;
    logic bCont;
    logic bEnd;
  } ctrlStrobe_t;
endpackage

// File: rtl/memwin_dpath.sv
`timescale 1ns/1ps
module memwin_dpath
  import memwin_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NW = NUM_WIN,
  parameter int KL = KEEP_LSB,
  parameter int BB = BEAT_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdValid,
  input  logic [AW-1:0] cmdAddr,
  input  logic          extMode,
  input  logic          regWrEn,
  input  logic          regSel,
  input  logic [AW-1:0] regWrData,
  input  ctrlStrobe_t   strobe,
  output logic [NW-1:0] hitVec,
  output logic          missOut,
  output logic [AW-1:0] pciAddr
);
  logic [AW-1:KL] bankHi;
  logic [AW-1:KL] maskHi;

  always_ff @(posedge clk) begin
    if (rst) begin
      bankHi <= '0;
      maskHi <= '0;
    end else if (regWrEn) begin
      if (regSel) maskHi <= regWrData[AW-1:KL];
      else        bankHi <= regWrData[AW-1:KL];
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_win
    localparam int LG = WIN_LOG2[w];
    localparam logic [AW-1:0] BASE = WIN_BASE[w];
    assign hitVec[w] = cmdValid
                    && (cmdAddr[AW-1:LG] == BASE[AW-1:LG])
                    && (!WIN_EXT_ONLY[w] || extMode);
  end

  assign missOut = cmdValid && !(|hitVec);

  always_comb begin
    pciAddr = '0;
    if (|hitVec) begin
      pciAddr[AW-1:KL] = (maskHi & bankHi) | (~maskHi & cmdAddr[AW-1:KL]);
      pciAddr[KL-1:0]  = cmdAddr[KL-1:0];
      if (strobe.lineXfer) pciAddr[BB-1:0] = '0;
    end
  end
endmodule

// File: rtl/memwin_ctrl.sv
`timescale 1ns/1ps
module memwin_ctrl
  import memwin_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NW = NUM_WIN,
  parameter int LB = LINE_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdValid,
  input  logic [1:0]    cmdKind,
  input  logic [AW-1:0] cmdAddr,
  input  logic [NW-1:0] hitVec,
  output ctrlStrobe_t   strobe
);
  logic          burstOpen;
  logic [AW-1:0] lastAddr;
  logic          lastWrite;
  logic [NW-1:0] lastWin;

  logic isLine, isWrite, take, follows;

  always_comb begin
    isLine  = (cmdKind == CMD_LOAD32) || (cmdKind == CMD_STORE32);
    isWrite = (cmdKind == CMD_STORE32);
    take    = cmdValid && (|hitVec);
    follows = burstOpen && (isWrite == lastWrite) && (hitVec == lastWin)
           && (cmdAddr == lastAddr + AW'(LB));
    strobe.lineXfer = cmdValid && isLine;
    strobe.bStart   = take && isLine && !follows;
    strobe.bCont    = take && isLine && follows;
    strobe.bEnd     = take && burstOpen && !(isLine && follows);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burstOpen <= 1'b0;
      lastAddr  <= '0;
      lastWrite <= 1'b0;
      lastWin   <= '0;
    end else if (take) begin
      burstOpen <= isLine;
      if (isLine) begin
        lastAddr  <= cmdAddr;
        lastWrite <= isWrite;
        lastWin   <= hitVec;
      end
    end
  end
endmodule

// File: rtl/memWinXlate.sv
`timescale 1ns/1ps
module memWinXlate
  import memwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmdValid,
  input  logic [1:0]  cmdKind,
  input  logic [31:0] cmdAddr,
  input  logic        extMode,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [31:0] regWrData,
  output logic [2:0]  hitWin,
  output logic        miss,
  output logic [31:0] pciAddr,
  output logic        burstStart,
  output logic        burstCont,
  output logic        burstEnd
);
  ctrlStrobe_t strobe;

  memwin_dpath u_dpath (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .extMode(extMode), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .strobe(strobe), .hitVec(hitWin),
    .missOut(miss), .pciAddr(pciAddr)
  );

  memwin_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdAddr(cmdAddr), .hitVec(hitWin), .strobe(strobe)
  );

  assign burstStart = strobe.bStart;
  assign burstCont  = strobe.bCont;
  assign burstEnd   = strobe.bEnd;
endmodule

// File: rtl/memwin_chk.sv
`timescale 1ns/1ps
module memwin_chk
  import memwin_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        cmdValid,
  input logic [1:0]  cmdKind,
  input logic [31:0] cmdAddr,
  input logic        extMode,
  input logic [2:0]  hitWin,
  input logic        miss,
  input logic [31:0] pciAddr,
  input logic        burstStart,
  input logic        burstCont,
  input logic        burstEnd
);
  logic lineCmd;
  assign lineCmd = (cmdKind == CMD_LOAD32) || (cmdKind == CMD_STORE32);

  assert_onehot_hit_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitWin) && !(miss && |hitWin));

  assert_ext_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !extMode |-> !hitWin[2]);

  assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    miss |-> (pciAddr == 32'h0) && !burstStart && !burstCont && !burstEnd);

  assert_passthru_R6: assert property (@(posedge clk) disable iff (rst)
    |hitWin |-> pciAddr[17:3] == cmdAddr[17:3]);

  assert_line_beat_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (|hitWin && lineCmd) |-> pciAddr[2:0] == 3'b000);

  assert_start_cont_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(burstStart && burstCont));

  assert_cont_needs_line_R8: assert property (@(posedge clk) disable iff (rst)
    burstCont |-> lineCmd && |hitWin);

  assert_reset_clears_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && |hitWin && !lineCmd) |-> pciAddr == cmdAddr && !burstEnd);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !cmdValid |-> hitWin == 3'b000 && !miss && pciAddr == 32'h0
                  && !burstStart && !burstCont && !burstEnd);
endmodule

bind memWinXlate memwin_chk u_chk (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdKind(cmdKind),
  .cmdAddr(cmdAddr), .extMode(extMode), .hitWin(hitWin), .miss(miss),
  .pciAddr(pciAddr), .burstStart(burstStart), .burstCont(burstCont),
  .burstEnd(burstEnd)
);

// File: tb/memWinXlate_bench.sv
`timescale 1ns/1ps
module memWinXlate_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmdValid;
  logic [1:0]  cmdKind;
  logic [31:0] cmdAddr;
  logic        extMode;
  logic        regWrEn;
  logic        regSel;
  logic [31:0] regWrData;
  logic [2:0]  hitWin;
  logic        miss;
  logic [31:0] pciAddr;
  logic        burstStart, burstCont, burstEnd;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  memWinXlate u_memWinXlate (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdAddr(cmdAddr), .extMode(extMode), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .hitWin(hitWin), .miss(miss),
    .pciAddr(pciAddr), .burstStart(burstStart), .burstCont(burstCont),
    .burstEnd(burstEnd)
  );

  typedef struct packed {
    logic        vld;
    logic [1:0]  kind;
    logic        ext;
    logic [31:0] addr;
    logic [2:0]  hit;
    logic        mis;
    logic [31:0] pci;
    logic        st;
    logic        ct;
    logic        en;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 1'b0, 32'hFD00_0004, 3'b001, 1'b0, 32'hFD00_0004, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 single
    '{1'b1, 2'd1, 1'b0, 32'hFD00_0040, 3'b001, 1'b0, 32'hFD00_0040, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 start
    '{1'b1, 2'd1, 1'b0, 32'hFD00_0060, 3'b001, 1'b0, 32'hFD00_0060, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 cont
    '{1'b1, 2'd1, 1'b0, 32'hFD00_0080, 3'b001, 1'b0, 32'hFD00_0080, 1'b0, 1'b1, 1'b0, 4'd8},
    '{1'b0, 2'd1, 1'b0, 32'hFD00_00A0, 3'b000, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 4'd12}, // R12 idle
    '{1'b1, 2'd1, 1'b0, 32'hFD00_00A0, 3'b001, 1'b0, 32'hFD00_00A0, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 survives idle
    '{1'b1, 2'd2, 1'b0, 32'hFD00_00C0, 3'b001, 1'b0, 32'hFD00_00C0, 1'b1, 1'b0, 1'b1, 4'd9},  // R9 dir change
    '{1'b1, 2'd2, 1'b0, 32'hFD00_00E5, 3'b001, 1'b0, 32'hFD00_00E0, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 beat bits zero
    '{1'b1, 2'd2, 1'b0, 32'hFE00_0000, 3'b000, 1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 4'd4},  // R4 reg region
    '{1'b1, 2'd2, 1'b0, 32'hFD00_0105, 3'b001, 1'b0, 32'hFD00_0100, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 state kept
    '{1'b1, 2'd2, 1'b0, 32'h1000_0000, 3'b010, 1'b0, 32'h1000_0000, 1'b1, 1'b0, 1'b1, 4'd2},  // R2
    '{1'b1, 2'd0, 1'b0, 32'h1000_0020, 3'b010, 1'b0, 32'h1000_0020, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 single closes
    '{1'b1, 2'd2, 1'b0, 32'h1000_0040, 3'b010, 1'b0, 32'h1000_0040, 1'b1, 1'b0, 1'b0, 4'd9},
    '{1'b1, 2'd1, 1'b0, 32'hC000_0000, 3'b000, 1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 4'd3},  // R3 ext off
    '{1'b1, 2'd1, 1'b1, 32'hC000_0000, 3'b100, 1'b0, 32'hC000_0000, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 ext on
    '{1'b1, 2'd0, 1'b1, 32'hFE20_0010, 3'b000, 1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 4'd4},  // R4 I/O region
    '{1'b1, 2'd0, 1'b1, 32'h2000_0000, 3'b000, 1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 4'd4},
    '{1'b1, 2'd0, 1'b1, 32'hDFFF_FFFC, 3'b100, 1'b0, 32'hDFFF_FFFC, 1'b0, 1'b0, 1'b1, 4'd9},
    '{1'b1, 2'd3, 1'b0, 32'h13FF_FFF1, 3'b010, 1'b0, 32'h13FF_FFF1, 1'b0, 1'b0, 1'b0, 4'd7}   // R7 code 3
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] outs();
    return {25'h0, hitWin, miss, pciAddr, burstStart, burstCont, burstEnd};
  endfunction

  task automatic cmd(input logic v, input logic [1:0] k, input logic x, input logic [31:0] a);
    @(negedge clk);
    cmdValid = v; cmdKind = k; extMode = x; cmdAddr = a;
    regWrEn = 1'b0;
    #1;
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cmdValid = 1'b0; regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cmdValid = 1'b0; cmdKind = 2'd0; cmdAddr = '0;
    extMode = 1'b0; regWrEn = 1'b0; regSel = 1'b0; regWrData = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset idle outputs", outs(), 64'h0);
    @(negedge clk);
    rst = 1'b0;

    // stimulus table, registers at reset values (identity translation)
    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i].vld, VEC[i].kind, VEC[i].ext, VEC[i].addr);
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), outs(),
          {25'h0, VEC[i].hit, VEC[i].mis, VEC[i].pci, VEC[i].st, VEC[i].ct, VEC[i].en});
    end

    // R5: bank/mask merge
    regWrite(1'b0, 32'h5A5A_5A5A);
    regWrite(1'b1, 32'hFFC0_0000);
    cmd(1'b1, 2'd0, 1'b0, 32'hFD12_3456);
    chk("R5 mask merge", {32'h0, pciAddr}, {32'h0, 32'h5A52_3456});

    // R5/R6: mask bits below 18 dropped
    regWrite(1'b1, 32'hFFFF_FFFF);
    cmd(1'b1, 2'd0, 1'b0, 32'hFD12_3456);
    chk("R6 low bits pass with full mask", {32'h0, pciAddr}, {32'h0, 32'h5A5A_3456});

    // R5: write visible only from the next edge
    @(negedge clk);
    cmdValid = 1'b1; cmdKind = 2'd0; cmdAddr = 32'hFD12_3456;
    regWrEn = 1'b1; regSel = 1'b0; regWrData = 32'h0;
    #1;
    chk("R5 same-cycle write sees old bank", {32'h0, pciAddr}, {32'h0, 32'h5A5A_3456});
    cmd(1'b1, 2'd0, 1'b0, 32'hFD12_3456);
    chk("R5 write visible next cycle", {32'h0, pciAddr}, {32'h0, 32'h0002_3456});

    // R11: reset clears registers and open burst
    regWrite(1'b0, 32'hFFFF_FFFF);
    cmd(1'b1, 2'd1, 1'b0, 32'h1000_0000);
    chk("R11 pre-reset start", {61'h0, burstStart, burstCont, burstEnd}, 64'h4);
    @(negedge clk);
    cmdValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cmd(1'b1, 2'd1, 1'b0, 32'h1000_0020);
    chk("R11 no continue after reset", outs(),
        {25'h0, 3'b010, 1'b0, 32'h1000_0020, 1'b1, 1'b0, 1'b0});

    cmd(1'b0, 2'd0, 1'b0, 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule